// File: doc/BRIEF.md
# Serial EEPROM-Style I2C Target

This block is an I2C target that looks to a bus master like a small serial EEPROM. It samples the SCL and SDA lines through synchronisers clocked by the system clock. It drives SDA open-drain: when `sda_oe` is high, the pad pulls the line low. The storage is a plain register array of `2**ADDR_W` bytes, organised into pages of `2**PAGE_W` bytes.

A master selects the block with a control byte. The upper nibble of that byte carries a device type code. The next three bits must equal the strapped `chip_sel` pins. The least significant bit gives the direction: 1 for read, 0 for write.

A write carries an address byte first, followed by any number of data bytes. A read streams bytes from an internal pointer until the master stops acknowledging. The pointer survives stop conditions, so current-address reads and sequential reads pick up where the last access ended. A random read is a write of the address only, then a repeated start, then a read. `ADDR_W` must not exceed 8.

Top module: `serial_mem_target`

## Requirements
- R1: A start (SDA falling while SCL is high) restarts control-byte reception at any point, including in the middle of a byte. A stop (SDA rising while SCL is high) returns the block to idle with `sda_oe` low.
- R2: `sda_oe` changes only while the synchronised SCL is low, except when a start or stop releases it.
- R3: The block reacts only to a control byte whose bits 7:4 equal `DEV_TYPE` (default 4'b1010) and whose bits 3:1 equal `chip_sel`; bit 0 is 1 for read and 0 for write. On a mismatch it gives no acknowledge and ignores all traffic up to the next start.
- R4: After every byte the block accepts, it holds `sda_oe` high through the ninth SCL clock.
- R5: In a write, the first byte after the control byte loads the pointer from its low `ADDR_W` bits. Each following byte is stored at the pointer, and the pointer then advances.
- R6: During writes the pointer advances only within its page: the low `PAGE_W` bits wrap and the upper bits stay the same.
- R7: A read sends bytes MSB first, starting at the pointer. The pointer advances by one after each byte is loaded and wraps over the whole array.
- R8: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A master no-acknowledge makes it release SDA and stay silent until the next start.
- R9: The pointer keeps its value across stop conditions, so a current-address read starts at the address after the last byte written or read.
- R10: A write carrying only an address byte, followed by a repeated start and a read control byte, reads from that address.
- R11: After reset the pointer is 0, every stored byte is 0 and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad (wired-AND bus value) |
| chip_sel | input | 3 | Strapped chip-select value compared with control-byte bits 3:1 |
| sda_oe | output | 1 | High to pull SDA low |

## Verification
The bench builds the block with `ADDR_W=4` and `PAGE_W=2`, giving a 16-byte array in pages of four bytes. With these sizes, short transfers of three or four bytes already cross a page edge during writes. The same sizes bring the end of the array within reach of sequential reads, so the page wrap and the array wrap are both exercised. A behavioural model holds the array and pointer as integers and predicts `sda_oe` on every system clock of each SCL high phase.

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 3,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} kind_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  wire        scl_s = scl_ff[1];
  wire        sda_s = sda_ff[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  st_t               state;
  kind_t             kind;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              rd_mode;
  logic              mack;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];

  wire [ADDR_W-1:0] ptr_lin = ptr + ADDR_W'(1);
  wire [ADDR_W-1:0] ptr_page;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign ptr_page = ptr_lin;
    end else begin : g_page
      assign ptr_page = {ptr[ADDR_W-1:PAGE_W], ptr_lin[PAGE_W-1:0]};
    end
  endgenerate

  wire       ctrl_hit  = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
  wire       byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  wire       wr_en     = byte_done && (kind == K_DATA);
  wire [7:0] rd_byte   = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[ptr] <= shreg;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= K_CTRL;
      bitcnt  <= 4'd0;
      shreg   <= 8'h00;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RX;
      kind   <= K_CTRL;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd0;
            case (kind)
              K_CTRL: begin
                if (ctrl_hit) begin
                  rd_mode <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              K_ADDR: begin
                ptr    <= shreg[ADDR_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              default: begin
                ptr    <= ptr_page;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (kind == K_CTRL && rd_mode) begin
              shreg  <= rd_byte;
              ptr    <= ptr_lin;
              sda_oe <= ~rd_byte[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              kind   <= (kind == K_CTRL) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= 4'd0;
            if (mack) begin
              shreg  <= rd_byte;
              ptr    <= ptr_lin;
              sda_oe <= ~rd_byte[7];
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/serial_mem_target_chk.sv
module serial_mem_target_chk #(
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              idle_q,
  input logic              ack_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] ptr
);
  assert_start_rearms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !idle_q));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && idle_q));

  assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  assert_ack_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> sda_oe);

  assert_silent_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !sda_oe);

  generate
    if (PAGE_W < ADDR_W) begin : g_page_chk
      assert_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
    end
  endgenerate
endmodule

bind serial_mem_target serial_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .idle_q(state == ST_IDLE), .ack_q(state == ST_ACK),
  .wr_en(wr_en), .ptr(ptr)
);

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int AW = 4;
  localparam int PW = 2;
  localparam int D  = 1 << AW;
  localparam int P  = 1 << PW;
  localparam logic [7:0] CTRL_W = 8'hAA;
  localparam logic [7:0] CTRL_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int m_mem [D];
  int m_ptr = 0;
  logic [7:0] wq[$];
  logic last_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mem_target #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel(3'b101), .sda_oe(sda_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic bus_bit(input logic b, input logic e_oe, input string req);
    sda_m = b;
    wait_q();
    scl_m = 1'b1;
    for (int k = 0; k < 2*Q; k++) begin
      @(negedge clk);
      chk({7'd0, sda_oe}, {7'd0, e_oe}, req);
      if (k == Q) last_line = sda_line;
    end
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e_ack, input string req);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req);
    bus_bit(1'b1, e_ack, req);
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic ack, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~e[i], req);
      got[i] = last_line;
    end
    chk(got, e, req);
    bus_bit(~ack, 1'b0, "R8");
  endtask

  function automatic int page_next(input int a);
    return (a & ~(P-1)) | ((a + 1) % P);
  endfunction

  task automatic read_stream(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = 8'(m_mem[m_ptr]);
      m_ptr = (m_ptr + 1) % D;
      recv_byte(e, k < n-1, req);
    end
  endtask

  task automatic wr_xfer(input int addr, input string req);
    do_start();
    send_byte(CTRL_W, 1'b1, "R4");
    send_byte(8'(addr), 1'b1, "R5");
    m_ptr = addr % D;
    foreach (wq[i]) begin
      send_byte(wq[i], 1'b1, req);
      m_mem[m_ptr] = int'(wq[i]);
      m_ptr = page_next(m_ptr);
    end
    do_stop();
  endtask

  task automatic rd_cur(input int n, input string req);
    do_start();
    send_byte(CTRL_R, 1'b1, "R3");
    read_stream(n, req);
    do_stop();
  endtask

  task automatic rd_rand(input int addr, input int n, input string req);
    do_start();
    send_byte(CTRL_W, 1'b1, "R10");
    send_byte(8'(addr), 1'b1, "R10");
    m_ptr = addr % D;
    do_start();
    send_byte(CTRL_R, 1'b1, "R10");
    read_stream(n, req);
    do_stop();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) m_mem[i] = 0;
    repeat (5) @(negedge clk);
    chk({7'd0, sda_oe}, 8'd0, "R11 oe in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({7'd0, sda_oe}, 8'd0, "R11 oe after reset");
    rd_cur(2, "R11 cleared array");

    wq = {8'hA5};
    wr_xfer(5, "R5 byte write");
    rd_rand(5, 1, "R10 random read");

    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    wr_xfer(6, "R6 page write");
    rd_rand(4, 4, "R6 page content");

    wq = {8'hE1, 8'hF2, 8'h9C};
    wr_xfer(14, "R6 page edge");
    rd_rand(15, 3, "R7 array wrap");
    rd_cur(2, "R9 current read");

    wq = {8'h5A, 8'hC3};
    wr_xfer(0, "R5 multi byte");
    rd_cur(1, "R9 after write");

    do_start();
    send_byte(8'hA8, 1'b0, "R3 wrong select");
    send_byte(8'h07, 1'b0, "R3 ignored");
    send_byte(8'hEE, 1'b0, "R3 ignored");
    do_stop();
    do_start();
    send_byte(8'hBA, 1'b0, "R3 wrong type");
    send_byte(8'h01, 1'b0, "R3 ignored");
    do_stop();
    rd_cur(2, "R3 state kept");

    do_start();
    bus_bit(1'b1, 1'b0, "R1");
    bus_bit(1'b0, 1'b0, "R1");
    bus_bit(1'b1, 1'b0, "R1");
    do_start();
    send_byte(CTRL_W, 1'b1, "R1 restart");
    send_byte(8'h09, 1'b1, "R1 restart");
    m_ptr = 9;
    send_byte(8'h6D, 1'b1, "R1 restart");
    m_mem[9] = 8'h6D;
    m_ptr = page_next(m_ptr);
    do_stop();
    rd_rand(9, 1, "R1 restart data");

    do_start();
    send_byte(CTRL_R, 1'b1, "R8");
    read_stream(1, "R8 nack");
    for (int k = 0; k < 3; k++) bus_bit(1'b1, 1'b0, "R8 silent after nack");
    do_stop();
    rd_cur(3, "R7 sequential");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule